// File: doc/BRIEF.md
# Rotate-Extend-Accumulate Datapath

This block picks a byte or a halfword out of a 32-bit source word, widens it by sign or zero extension, and can add the widened value to a second 32-bit operand. The field is selected by turning the source word right by a whole number of bytes. The word wraps around circularly, so a halfword chosen at the top byte position takes its high byte from the bottom of the source. A dual-lane mode takes two bytes that sit 16 bits apart in the rotated word. It widens each byte to 16 bits and places them in the low and high halfwords of the result. Each lane can add its own halfword of the second operand, and no carry passes between the lanes.

The arithmetic is combinational. One output register at the edge of the block gives a fixed latency of one clock. An operation code chooses byte or halfword, signed or unsigned, single or dual lane, and accumulate or plain extract. It is typically placed in the execute stage of an integer pipeline.

Top module: `rext_datapath`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result_o` becomes zero after that edge, whatever the data inputs are.
- R2: The effective rotation is 8 × `rot_i[4:3]` bits to the right. `rot_i[2:0]` has no effect on the result.
- R3: With `op_i` = 4'b0000 (unsigned single byte), the result is the low byte of the rotated source, zero-extended to 32 bits.
- R4: With `op_i` = 4'b0001 (signed single byte), the result is the low byte of the rotated source, sign-extended to 32 bits.
- R5: With `op_i[1]` = 1 and `op_i[2]` = 0 (halfword), the result is the low 16 bits of the circularly rotated source. `op_i[0]` selects sign extension. At a rotation of 24 the field is {src[7:0], src[31:24]}.
- R6: With `op_i[3]` = 1 in single-lane mode, the result is the extended value plus `acc_i`, taken modulo 2^32.
- R7: With `op_i[2]` = 1 (dual lane), bits 15:0 hold rotated-source bits 7:0 and bits 31:16 hold rotated-source bits 23:16. Each byte is extended to 16 bits, signed when `op_i[0]` = 1.
- R8: In dual-lane mode with `op_i[3]` = 1, each lane adds the matching halfword of `acc_i` modulo 2^16. No carry goes from the low lane into the high lane.
- R9: `result_o` changes only at a rising clock edge. It reflects the inputs sampled at that edge.
- R10: In dual-lane mode `op_i[1]` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Source word from which the field is taken |
| acc_i | input | 32 | Accumulate operand, whole word or two halfword lanes |
| rot_i | input | 5 | Rotate amount in bits; only bits 4:3 are used |
| op_i | input | 4 | [0] signed, [1] halfword, [2] dual lane, [3] accumulate |
| result_o | output | 32 | Registered result |

## Verification
The hardest case to reach is a dual-lane accumulate where the low lane overflows. There the sum of the widened byte and the accumulate halfword passes 16 bits, and a carry that leaked into the upper lane would be visible. Random data rarely produces this with a clean upper lane, so a directed vector builds it from a 0xFF byte and a low accumulate halfword of 0xFF01. The wrap-around halfword at rotation 24 and rotate amounts with nonzero low bits are also set up directly. A sweep then covers every operation code against all 32 rotate values with random words.

// File: rtl/rext_pkg.sv
`timescale 1ns/1ps
package rext_pkg;
  // Operation code layout, MSB first: accumulate, dual, halfword, signed
  typedef struct packed {
    logic acc;
    logic dual;
    logic half;
    logic sgn;
  } rext_op_t;

  localparam int OP_W = 4;
endpackage

// File: rtl/rext_rotator.sv
`timescale 1ns/1ps
module rext_rotator #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int NB     = DATA_W / BYTE_W,
  localparam int STEP_W = $clog2(NB)
) (
  input  logic [DATA_W-1:0] src,
  input  logic [STEP_W-1:0] step,
  output logic [DATA_W-1:0] rotated
);
  // Byte-granular right rotation: output byte k takes source byte (k+step) mod NB
  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic [STEP_W-1:0] idx;
    assign idx = STEP_W'(k) + step;
    assign rotated[k*BYTE_W +: BYTE_W] = src[idx*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/rext_extend.sv
`timescale 1ns/1ps
module rext_extend #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 16,
  parameter int BYTE_W = 8,
  localparam int NL = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] rotated,
  input  logic              sgn,
  input  logic              half,
  output logic [DATA_W-1:0] single_ext,
  output logic [DATA_W-1:0] dual_ext
);
  logic fill_b, fill_h;
  logic spare_unused;

  assign spare_unused = ^rotated;
  assign fill_b = sgn & rotated[BYTE_W-1];
  assign fill_h = sgn & rotated[LANE_W-1];

  always_comb begin
    if (half)
      single_ext = {{(DATA_W-LANE_W){fill_h}}, rotated[LANE_W-1:0]};
    else
      single_ext = {{(DATA_W-BYTE_W){fill_b}}, rotated[BYTE_W-1:0]};
  end

  // Each lane widens the byte at the bottom of its halfword
  for (genvar j = 0; j < NL; j++) begin : g_lane
    logic [BYTE_W-1:0] b;
    assign b = rotated[j*LANE_W +: BYTE_W];
    assign dual_ext[j*LANE_W +: LANE_W] = {{(LANE_W-BYTE_W){sgn & b[BYTE_W-1]}}, b};
  end
endmodule

// File: rtl/rext_accum.sv
`timescale 1ns/1ps
module rext_accum #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 16,
  localparam int NL = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] single_ext,
  input  logic [DATA_W-1:0] dual_ext,
  input  logic [DATA_W-1:0] acc_in,
  input  logic              dual,
  input  logic              acc,
  output logic [DATA_W-1:0] sum
);
  logic [DATA_W-1:0] addend;
  logic [DATA_W-1:0] single_sum;
  logic [DATA_W-1:0] dual_sum;

  assign addend     = acc ? acc_in : '0;
  assign single_sum = single_ext + addend;

  // Independent adders per lane; carry out of each lane is dropped
  for (genvar j = 0; j < NL; j++) begin : g_lane_add
    assign dual_sum[j*LANE_W +: LANE_W] =
      dual_ext[j*LANE_W +: LANE_W] + addend[j*LANE_W +: LANE_W];
  end

  assign sum = dual ? dual_sum : single_sum;
endmodule

// File: rtl/rext_datapath.sv
`timescale 1ns/1ps
module rext_datapath #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 16,
  parameter int BYTE_W = 8,
  localparam int ROT_W  = $clog2(DATA_W),
  localparam int STEP_W = $clog2(DATA_W / BYTE_W),
  localparam int LOW_W  = ROT_W - STEP_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [DATA_W-1:0]           src_i,
  input  logic [DATA_W-1:0]           acc_i,
  input  logic [ROT_W-1:0]            rot_i,
  input  logic [rext_pkg::OP_W-1:0]   op_i,
  output logic [DATA_W-1:0]           result_o
);
  import rext_pkg::*;

  rext_op_t          op;
  logic [DATA_W-1:0] rot_word;
  logic [DATA_W-1:0] single_ext;
  logic [DATA_W-1:0] dual_ext;
  logic [DATA_W-1:0] sum_w;
  logic [LOW_W-1:0]  rot_low_unused;

  assign op             = rext_op_t'(op_i);
  assign rot_low_unused = rot_i[LOW_W-1:0];

  rext_rotator #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_rot (
    .src     (src_i),
    .step    (rot_i[ROT_W-1 -: STEP_W]),
    .rotated (rot_word)
  );

  rext_extend #(.DATA_W(DATA_W), .LANE_W(LANE_W), .BYTE_W(BYTE_W)) u_ext (
    .rotated    (rot_word),
    .sgn        (op.sgn),
    .half       (op.half),
    .single_ext (single_ext),
    .dual_ext   (dual_ext)
  );

  rext_accum #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_acc (
    .single_ext (single_ext),
    .dual_ext   (dual_ext),
    .acc_in     (acc_i),
    .dual       (op.dual),
    .acc        (op.acc),
    .sum        (sum_w)
  );

  always_ff @(posedge clk) begin
    if (rst) result_o <= '0;
    else     result_o <= sum_w;
  end

  // Rotation only permutes bits, so the population count is unchanged
  assert_rot_popcount_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(rot_word) == $countones(src_i));

  assert_ubyte_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (!op.dual && !op.half && !op.sgn) |->
      (single_ext[DATA_W-1:BYTE_W] == '0 &&
       single_ext[BYTE_W-1:0] == rot_word[BYTE_W-1:0]));

  assert_sbyte_fill_R4: assert property (@(posedge clk) disable iff (rst)
    (!op.dual && !op.half && op.sgn) |->
      ($countones(single_ext[DATA_W-1:BYTE_W]) ==
       (rot_word[BYTE_W-1] ? DATA_W-BYTE_W : 0)));

  assert_acc_diff_R6: assert property (@(posedge clk) disable iff (rst)
    (!op.dual && op.acc) |-> ((sum_w - acc_i) == single_ext));

  assert_lane_nocarry_R8: assert property (@(posedge clk) disable iff (rst)
    (op.dual && op.acc) |->
      (LANE_W'(sum_w[LANE_W-1:0] - acc_i[LANE_W-1:0]) == dual_ext[LANE_W-1:0] &&
       LANE_W'(sum_w[DATA_W-1 -: LANE_W] - acc_i[DATA_W-1 -: LANE_W]) ==
         dual_ext[DATA_W-1 -: LANE_W]));
endmodule

// File: tb/sim_rext_datapath.sv
`timescale 1ns/1ps
module sim_rext_datapath;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_i = '0;
  logic [31:0] acc_i = '0;
  logic [4:0]  rot_i = '0;
  logic [3:0]  op_i  = '0;
  logic [31:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rext_datapath u0 (
    .clk(clk), .rst(rst), .src_i(src_i), .acc_i(acc_i),
    .rot_i(rot_i), .op_i(op_i), .result_o(result_o)
  );

  function automatic logic [31:0] model(input logic [31:0] s, input logic [31:0] a,
                                        input logic [4:0] r, input logic [3:0] o);
    int unsigned amt;
    logic [63:0] dbl;
    logic [31:0] rw, e, sh;
    logic [15:0] l0, l1;
    amt = 32'(r[4:3]) * 8;
    dbl = {s, s} >> amt;
    rw  = dbl[31:0];
    if (o[2]) begin
      l0 = o[0] ? {{8{rw[7]}}, rw[7:0]}   : {8'h00, rw[7:0]};
      l1 = o[0] ? {{8{rw[23]}}, rw[23:16]} : {8'h00, rw[23:16]};
      if (o[3]) begin
        l0 = l0 + a[15:0];
        l1 = l1 + a[31:16];
      end
      return {l1, l0};
    end
    if (o[1]) e = o[0] ? {{16{rw[15]}}, rw[15:0]} : {16'h0, rw[15:0]};
    else begin
      sh = s >> amt;
      e  = o[0] ? {{24{sh[7]}}, sh[7:0]} : {24'h0, sh[7:0]};
    end
    if (o[3]) e = e + a;
    return e;
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    if (o[2]) return o[3] ? "R8" : "R7";
    if (o[3]) return "R6";
    if (o[1]) return "R5";
    return o[0] ? "R4" : "R3";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] s, input logic [31:0] a, input logic [4:0] r,
                     input logic [3:0] o, input string tag, input logic [31:0] exp);
    @(negedge clk);
    src_i = s; acc_i = a; rot_i = r; op_i = o;
    @(negedge clk);
    check(tag, result_o, exp);
  endtask

  initial begin
    // R1: reset clears the register even with live inputs
    @(negedge clk);
    src_i = 32'hDEAD_BEEF; acc_i = 32'h1234_5678; rot_i = 5'd8; op_i = 4'b1011;
    @(negedge clk);
    check("R1", result_o, 32'h0);
    @(negedge clk);
    check("R1", result_o, 32'h0);
    rst = 1'b0;

    // R2: low rotate bits ignored
    run(32'h89AB_CDEF, 0, 5'd8,  4'b0000, "R2", 32'h0000_00CD);
    run(32'h89AB_CDEF, 0, 5'd9,  4'b0000, "R2", 32'h0000_00CD);
    run(32'h89AB_CDEF, 0, 5'd15, 4'b0000, "R2", 32'h0000_00CD);
    run(32'h89AB_CDEF, 0, 5'd31, 4'b0000, "R2", 32'h0000_0089);
    // R3 / R4 byte extension
    run(32'h0000_8000, 0, 5'd8, 4'b0000, "R3", 32'h0000_0080);
    run(32'h0000_8000, 0, 5'd8, 4'b0001, "R4", 32'hFFFF_FF80);
    // R5: circular halfword at rotation 24
    run(32'h1234_5678, 0, 5'd24, 4'b0010, "R5", 32'h0000_7812);
    run(32'h0000_0080, 0, 5'd24, 4'b0011, "R5", 32'hFFFF_8000);
    // R6: full-width wrap
    run(32'h0000_00FF, 32'h0000_0001, 5'd0, 4'b1001, "R6", 32'h0000_0000);
    run(32'h0000_0002, 32'hFFFF_FFFF, 5'd0, 4'b1010, "R6", 32'h0000_0001);
    // R7: dual lane with upper byte wrapping
    run(32'h0080_0001, 0, 5'd16, 4'b0101, "R7", 32'h0001_FF80);
    // R8: low-lane overflow must not reach high lane
    run(32'h00FF_00FF, 32'h0000_FF01, 5'd0, 4'b1100, "R8", 32'h00FF_0000);
    run(32'h0080_0080, 32'h0080_0080, 5'd0, 4'b1101, "R8", 32'h0000_0000);
    // R10: halfword bit ignored in dual mode
    run(32'h1122_3344, 0, 5'd0, 4'b0100, "R10", 32'h0022_0044);
    run(32'h1122_3344, 0, 5'd0, 4'b0110, "R10", 32'h0022_0044);

    // R9: output holds between edges
    @(negedge clk);
    src_i = 32'h0000_0055; acc_i = 0; rot_i = 0; op_i = 4'b0000;
    @(negedge clk);
    check("R9", result_o, 32'h0000_0055);
    src_i = 32'h0000_00AA;
    #2;
    check("R9", result_o, 32'h0000_0055);
    @(negedge clk);
    check("R9", result_o, 32'h0000_00AA);

    // Sweep every op code and rotate value
    for (int o = 0; o < 16; o++) begin
      for (int r = 0; r < 32; r++) begin
        for (int k = 0; k < 4; k++) begin
          logic [31:0] s, a;
          s = $urandom;
          a = $urandom;
          run(s, a, 5'(r), 4'(o), tag_of(4'(o)), model(s, a, 5'(r), 4'(o)));
        end
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule